// File: doc/BRIEF.md
# Texture and Sampler Descriptor Fetch

This block sits in front of a texturing unit and collects the two descriptors that one sample operation needs. Each request brings a 64-bit descriptor-table base taken from uniform state that a whole thread group shares. It also brings a 32-bit byte offset that is chosen per thread and can change on every request, a 16-bit sampler number, the sample dimensionality and a tag. The texture descriptor is 24 bytes long and sits at base plus offset in memory. The block reads it as three 64-bit beats over a plain request/response memory port. The 8-byte sampler descriptor comes from an on-chip global table that is addressed directly by the sampler number. No base address is involved for the sampler.

The block takes one request at a time. When both descriptors are ready, it presents them together with the echoed tag and dimensionality on a valid/ready response port. Requests that cannot be legal are answered with an error flag and cause no memory traffic. A request is illegal when its offset is not a whole number of 24-byte slots or its sampler number lies past the end of the table. Software fills the sampler table through a separate write port.

Top module: `tex_desc_fetch`

## Requirements
- R1: While reset is asserted and directly after it is released, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: The texture descriptor address is `req_tbl_base` plus the zero-extended `req_off`, computed as a full 64-bit sum. The block issues exactly three memory reads, one at a time, at that address +0, +8 and +16 in that order. Each read holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready` is 1.
- R3: The first returned beat lands in `rsp_tex[63:0]`, the second in `rsp_tex[127:64]` and the third in `rsp_tex[191:128]`.
- R4: `rsp_samp` carries the sampler table entry selected by `req_samp[9:0]`. The entry is read in the cycle the request is accepted.
- R5: A sampler table write takes effect from the cycle after it is accepted. A write in the same cycle as a request acceptance is not seen by that request, but it is seen by the next one.
- R6: If `req_off` is not a multiple of 24, the response has `rsp_err`=1, `rsp_tex`=0 and `rsp_samp`=0. No memory read is issued, and `rsp_valid` rises in the cycle after acceptance.
- R7: If `req_samp` is 1024 or more, the response behaves as in R6: the error flag is set, both descriptors are zero and no memory read is issued.
- R8: `rsp_tag` and `rsp_dim` return the values of `req_tag` and `req_dim` captured at acceptance.
- R9: Only one request is in flight. `req_ready` is 0 from the cycle after acceptance until the cycle after the `rsp_valid`/`rsp_ready` handshake. While `rsp_ready` is 0, the response fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_tbl_base | input | 64 | Descriptor table base address (shared uniform state) |
| req_off | input | 32 | Byte offset of the texture descriptor |
| req_samp | input | 16 | Sampler number |
| req_dim | input | 2 | Sample dimensionality code, echoed |
| req_tag | input | TAG_W | Request tag, echoed |
| samp_wr_en | input | 1 | Sampler table write strobe |
| samp_wr_idx | input | 10 | Sampler table write index |
| samp_wr_data | input | 64 | Sampler descriptor to write |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the 64-bit beat |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Read data beat |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_tex | output | 192 | Assembled texture descriptor |
| rsp_samp | output | 64 | Sampler descriptor |
| rsp_dim | output | 2 | Echoed dimensionality |
| rsp_tag | output | TAG_W | Echoed tag |
| rsp_err | output | 1 | Illegal offset or sampler number |

## Verification
The bench uses a base and offset whose sum carries out of the low 32 bits. A design that adds only the low word would fetch from the wrong page. It also uses the largest 32-bit offset that is still a multiple of 24, which a narrow divisibility check would reject. Both kinds of illegal request are sent, an offset one byte off a slot and sampler numbers at and beyond the table end. A design that leaked a memory read on these would be caught by the bench's read counter. A sampler write placed in the same cycle as an acceptance exposes write-through forwarding. A stalled memory ready and a held response show whether a design drops a beat, reorders beats, or lets the response change before it is taken.

// File: rtl/tdf_pkg.sv
package tdf_pkg;
  localparam int ADDR_W     = 64;
  localparam int OFF_W      = 32;
  localparam int SIDX_W     = 16;
  localparam int DIM_W      = 2;
  localparam int BEAT_W     = 64;
  localparam int TEX_BYTES  = 24;
  localparam int SAMP_W     = 64;
  localparam int SAMP_DEPTH = 1024;

  localparam int BEAT_BYTES = BEAT_W / 8;
  localparam int TEX_W      = TEX_BYTES * 8;
  localparam int TEX_BEATS  = TEX_W / BEAT_W;
  localparam int SAMP_AW    = $clog2(SAMP_DEPTH);
  localparam int BEAT_CW    = $clog2(TEX_BEATS + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } fetch_st_e;
endpackage

// File: rtl/tdf_req_check.sv
module tdf_req_check
  import tdf_pkg::*;
(
  input  logic [ADDR_W-1:0]  tbl_base,
  input  logic [OFF_W-1:0]   byte_off,
  input  logic [SIDX_W-1:0]  samp_num,
  output logic [ADDR_W-1:0]  tex_addr,
  output logic [SAMP_AW-1:0] samp_idx,
  output logic               bad
);
  logic off_bad;
  logic samp_bad;

  always_comb begin
    tex_addr = tbl_base + ADDR_W'(byte_off);
    samp_idx = samp_num[SAMP_AW-1:0];
    off_bad  = (byte_off % OFF_W'(TEX_BYTES)) != '0;
    samp_bad = samp_num >= SIDX_W'(SAMP_DEPTH);
    bad      = off_bad | samp_bad;
  end
endmodule

// File: rtl/tdf_samp_table.sv
module tdf_samp_table
  import tdf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SAMP_AW-1:0] wr_idx,
  input  logic [SAMP_W-1:0]  wr_data,
  input  logic [SAMP_AW-1:0] rd_idx,
  output logic [SAMP_W-1:0]  rd_data
);
  logic [SAMP_W-1:0] entry_q [SAMP_DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      entry_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = entry_q[rd_idx];

  // R5
  wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (entry_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/tdf_beat_asm.sv
module tdf_beat_asm
  import tdf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               ld,
  input  logic [BEAT_CW-1:0] sel,
  input  logic [BEAT_W-1:0]  din,
  output logic [TEX_W-1:0]   tex
);
  for (genvar g = 0; g < TEX_BEATS; g++) begin : g_beat
    logic [BEAT_W-1:0] beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        beat_q <= '0;
      end else if (clr) begin
        beat_q <= '0;
      end else if (ld && (sel == BEAT_CW'(g))) begin
        beat_q <= din;
      end
    end

    assign tex[g*BEAT_W +: BEAT_W] = beat_q;
  end
endmodule

// File: rtl/tex_desc_fetch.sv
module tex_desc_fetch
  import tdf_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_tbl_base,
  input  logic [OFF_W-1:0]   req_off,
  input  logic [SIDX_W-1:0]  req_samp,
  input  logic [DIM_W-1:0]   req_dim,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic               samp_wr_en,
  input  logic [SAMP_AW-1:0] samp_wr_idx,
  input  logic [SAMP_W-1:0]  samp_wr_data,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [BEAT_W-1:0]  mem_rsp_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [TEX_W-1:0]   rsp_tex,
  output logic [SAMP_W-1:0]  rsp_samp,
  output logic [DIM_W-1:0]   rsp_dim,
  output logic [TAG_W-1:0]   rsp_tag,
  output logic               rsp_err
);
  fetch_st_e          state_q, state_d;
  logic [BEAT_CW-1:0] beat_q, beat_d;
  logic [ADDR_W-1:0]  addr_q;
  logic [TAG_W-1:0]   tag_q;
  logic [DIM_W-1:0]   dim_q;
  logic [SAMP_W-1:0]  samp_q;
  logic               err_q;

  logic               accept;
  logic               bad;
  logic               beat_ld;
  logic [ADDR_W-1:0]  tex_addr;
  logic [SAMP_AW-1:0] samp_idx;
  logic [SAMP_W-1:0]  samp_rd;

  tdf_req_check i_check (
    .tbl_base (req_tbl_base),
    .byte_off (req_off),
    .samp_num (req_samp),
    .tex_addr (tex_addr),
    .samp_idx (samp_idx),
    .bad      (bad)
  );

  tdf_samp_table i_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (samp_wr_en),
    .wr_idx  (samp_wr_idx),
    .wr_data (samp_wr_data),
    .rd_idx  (samp_idx),
    .rd_data (samp_rd)
  );

  tdf_beat_asm i_asm (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .ld    (beat_ld),
    .sel   (beat_q),
    .din   (mem_rsp_data),
    .tex   (rsp_tex)
  );

  assign accept = req_valid && (state_q == ST_IDLE);

  // next state
  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    beat_ld = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = bad ? ST_DONE : ST_ADDR;
          beat_d  = '0;
        end
      end
      ST_ADDR: begin
        if (mem_req_ready) state_d = ST_DATA;
      end
      ST_DATA: begin
        if (mem_rsp_valid) begin
          beat_ld = 1'b1;
          beat_d  = beat_q + 1'b1;
          state_d = (beat_q == BEAT_CW'(TEX_BEATS - 1)) ? ST_DONE : ST_ADDR;
        end
      end
      ST_DONE: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      tag_q  <= '0;
      dim_q  <= '0;
      samp_q <= '0;
      err_q  <= 1'b0;
    end else if (accept) begin
      addr_q <= tex_addr;
      tag_q  <= req_tag;
      dim_q  <= req_dim;
      samp_q <= bad ? '0 : samp_rd;
      err_q  <= bad;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ADDR);
  assign mem_req_addr  = addr_q + ADDR_W'(beat_q) * ADDR_W'(BEAT_BYTES);
  assign rsp_valid     = (state_q == ST_DONE);
  assign rsp_samp      = samp_q;
  assign rsp_dim       = dim_q;
  assign rsp_tag       = tag_q;
  assign rsp_err       = err_q;

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_tex) &&
                                   $stable(rsp_samp) && $stable(rsp_tag)));

  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R6 R7
  err_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && bad) |=> (rsp_valid && rsp_err && !mem_req_valid));
endmodule

// File: tb/test_tex_desc_fetch.sv
module test_tex_desc_fetch;
  localparam int CLK_P = 10;
  localparam int TW    = 8;

  typedef struct packed {
    logic [63:0] base;
    logic [31:0] off;
    logic [15:0] samp;
    logic [1:0]  dim;
    logic        stall;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_1000_0000, 32'd0,          16'd0,      2'd1, 1'b0},
    '{64'h0000_0000_1000_0000, 32'd120,        16'd3,      2'd2, 1'b0},
    '{64'h0000_0000_FFFF_FFF8, 32'd24,         16'd1023,   2'd0, 1'b0},
    '{64'h0000_0000_0000_2000, 32'd48,         16'd500,    2'd3, 1'b1},
    '{64'h0000_0000_0000_3000, 32'd25,         16'd3,      2'd1, 1'b0},
    '{64'h0000_0000_0000_3000, 32'd24,         16'd1024,   2'd2, 1'b0},
    '{64'h0000_0001_0000_3000, 32'hFFFF_FFF0,  16'd12,     2'd1, 1'b1},
    '{64'h0000_0000_0000_3000, 32'd0,          16'hFFFF,   2'd0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready;
  logic [63:0] req_tbl_base;
  logic [31:0] req_off;
  logic [15:0] req_samp;
  logic [1:0]  req_dim;
  logic [TW-1:0] req_tag;
  logic samp_wr_en;
  logic [9:0] samp_wr_idx;
  logic [63:0] samp_wr_data;
  logic mem_req_valid, mem_req_ready;
  logic [63:0] mem_req_addr;
  logic mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic rsp_valid, rsp_ready;
  logic [191:0] rsp_tex;
  logic [63:0] rsp_samp;
  logic [1:0] rsp_dim;
  logic [TW-1:0] rsp_tag;
  logic rsp_err;

  int total = 0;
  int bad_n = 0;
  int n_memreq = 0;
  logic [63:0] alog0, alog1, alog2;
  logic stall_on = 1'b0;
  logic [7:0] cyc = '0;
  logic [63:0] shadow [1024];

  tex_desc_fetch #(.TAG_W(TW)) i_tex_desc_fetch (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_tbl_base(req_tbl_base), .req_off(req_off), .req_samp(req_samp),
    .req_dim(req_dim), .req_tag(req_tag),
    .samp_wr_en(samp_wr_en), .samp_wr_idx(samp_wr_idx), .samp_wr_data(samp_wr_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tex(rsp_tex),
    .rsp_samp(rsp_samp), .rsp_dim(rsp_dim), .rsp_tag(rsp_tag), .rsp_err(rsp_err)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [63:0] fmem(input logic [63:0] a);
    return a ^ 64'h0F0F_3C3C_A5A5_5A5A;
  endfunction

  // memory model: one-cycle read latency, optional alternate-cycle stall
  assign mem_req_ready = !(stall_on && cyc[0]);
  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
    end else if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= fmem(mem_req_addr);
      n_memreq      <= n_memreq + 1;
      alog0 <= mem_req_addr;
      alog1 <= alog0;
      alog2 <= alog1;
    end else begin
      mem_rsp_valid <= 1'b0;
    end
  end

  task automatic chk(input string rq, input string what,
                     input logic [191:0] act, input logic [191:0] exp);
    total++;
    if (act !== exp) begin
      bad_n++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic wr_samp(input logic [9:0] idx, input logic [63:0] d);
    @(negedge clk);
    samp_wr_en = 1'b1; samp_wr_idx = idx; samp_wr_data = d;
    @(negedge clk);
    samp_wr_en = 1'b0;
    shadow[idx] = d;
  endtask

  task automatic run_req(input logic [63:0] base, input logic [31:0] off,
                         input logic [15:0] samp, input logic [1:0] dim,
                         input logic [TW-1:0] tag, input string srq,
                         input bit wr_too, input logic [9:0] widx,
                         input logic [63:0] wdat);
    logic exp_err;
    logic [63:0] a, exp_samp;
    logic [191:0] exp_tex, held_tex;
    int n0, waited;
    exp_err  = ((off % 32'd24) != 0) || (samp >= 16'd1024);
    exp_samp = exp_err ? 64'd0 : shadow[samp[9:0]];
    a        = base + {32'd0, off};
    exp_tex  = exp_err ? 192'd0 : {fmem(a + 64'd16), fmem(a + 64'd8), fmem(a)};
    n0 = n_memreq;
    @(negedge clk);
    req_valid = 1'b1; req_tbl_base = base; req_off = off; req_samp = samp;
    req_dim = dim; req_tag = tag;
    if (wr_too) begin
      samp_wr_en = 1'b1; samp_wr_idx = widx; samp_wr_data = wdat;
    end
    @(negedge clk);
    req_valid = 1'b0; samp_wr_en = 1'b0;
    if (wr_too) shadow[widx] = wdat;
    waited = 0;
    while (!rsp_valid && waited < 1000) begin
      @(negedge clk);
      waited++;
    end
    chk(exp_err ? "R6/R7 err" : "R2", "rsp_err", {191'd0, rsp_err}, {191'd0, exp_err});
    chk("R3", "rsp_tex", rsp_tex, exp_tex);
    chk(srq, "rsp_samp", {128'd0, rsp_samp}, {128'd0, exp_samp});
    chk("R8", "tag/dim", {182'd0, rsp_tag, rsp_dim}, {182'd0, tag, dim});
    chk("R9", "req_ready busy", {191'd0, req_ready}, 192'd0);
    if (exp_err) begin
      chk("R6 R7", "mem reads", 192'(n_memreq - n0), 192'd0);
      chk("R6 R7", "latency", 192'(waited), 192'd0);
    end else begin
      chk("R2", "mem reads", 192'(n_memreq - n0), 192'd3);
      chk("R2", "beat addrs", {alog2, alog1, alog0}, {a, a + 64'd8, a + 64'd16});
    end
    held_tex = rsp_tex;
    @(negedge clk);
    chk("R9", "held valid", {191'd0, rsp_valid}, {191'd0, 1'b1});
    chk("R9", "held tex", rsp_tex, held_tex);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R9", "after handshake", {190'd0, rsp_valid, req_ready}, {190'd0, 1'b0, 1'b1});
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad_n++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad_n);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_tbl_base = '0; req_off = '0; req_samp = '0;
    req_dim = '0; req_tag = '0; rsp_ready = 1'b0;
    samp_wr_en = 1'b0; samp_wr_idx = '0; samp_wr_data = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "reset outs", {189'd0, req_ready, rsp_valid, mem_req_valid}, {189'd0, 3'b100});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "after reset", {189'd0, req_ready, rsp_valid, mem_req_valid}, {189'd0, 3'b100});

    wr_samp(10'd0,    64'hC0DE_0000_0000_0000);
    wr_samp(10'd3,    64'hC0DE_0003_1111_2222);
    wr_samp(10'd1023, 64'hC0DE_03FF_3333_4444);
    wr_samp(10'd500,  64'hC0DE_01F4_5555_6666);
    wr_samp(10'd12,   64'hC0DE_000C_7777_8888);

    for (int i = 0; i < NV; i++) begin
      stall_on = VECS[i].stall;
      run_req(VECS[i].base, VECS[i].off, VECS[i].samp, VECS[i].dim,
              TW'(8'h40 + i), "R4", 1'b0, 10'd0, 64'd0);
    end
    stall_on = 1'b0;

    // R5: write in the acceptance cycle is not seen, later request sees it
    begin
      logic [63:0] old3;
      old3 = shadow[3];
      run_req(64'h8000, 32'd72, 16'd3, 2'd1, 8'hA5, "R5", 1'b1, 10'd3,
              64'hFEED_FACE_0BAD_CAFE);
      chk("R5", "shadow moved", {128'd0, shadow[3]}, {128'd0, 64'hFEED_FACE_0BAD_CAFE});
      if (old3 == shadow[3]) chk("R5", "distinct data", 192'd0, 192'd1);
      run_req(64'h8000, 32'd0, 16'd3, 2'd2, 8'hA6, "R5", 1'b0, 10'd0, 64'd0);
    end

    $display("test done: total=%0d bad=%0d", total, bad_n);
    $finish;
  end
endmodule